// File: doc/BRIEF.md
# Fuzzable Shadow Lookup Table

This block replaces an internal lookup table, such as a branch target table, a cache tag array or a valid-bit array. It keeps a shadow copy with the same number of entries and the same entry width, and it answers every design read from that copy. The original read and write ports keep their normal behaviour. A built-in mutation engine can overwrite shadow entries while the design runs. The surrounding logic then sees table contents that no program could produce on its own, such as valid branch entries with bogus targets, or tags that pull every access toward one bank.

The engine is driven by a 16-bit LFSR that is seeded at reset release and by a programmable period counter. On each firing cycle it picks an entry index from the LFSR state and writes a value built according to the selected mode: pure random, a fixed pattern, valid-plus-bank steering, or valid-plus-random target. A pulse output and an index output mark each applied mutation, so a testbench can line up mutations with mismatches in co-simulation. When the mutation enable is low, the wrapper acts exactly like a plain registered table.

Top module: `fuzz_table_wrap`

## Requirements
- R1: The table holds DEPTH entries of DATA_W bits, all zero after reset, and `rd_data_o` is zero during reset. A read with `rd_en_i` high returns the entry on the next clock edge. A read of an address at or above DEPTH returns zero. With `rd_en_i` low, `rd_data_o` holds its value.
- R2: A design write stores `wr_data_i` at `wr_addr_i`. Writes to addresses at or above DEPTH are dropped. A read of the address being written in the same cycle returns the new data.
- R3: On the first clock edge after reset release, the LFSR loads `seed_i`, or 16'hACE1 when `seed_i` is zero. No mutation is applied in that cycle.
- R4: The LFSR shifts left with feedback bit0 = s[15]^s[13]^s[12]^s[10]. It advances only in cycles in which a mutation is applied.
- R5: While enabled, a mutation fires in the first eligible cycle, then once every `mut_period_i` cycles. A period of 0 or 1 fires every cycle. Disabling clears the countdown.
- R6: The mutated index is the LFSR state modulo DEPTH. `mut_pulse_o` and `mut_idx_o` report it in the same cycle in which the write is applied.
- R7: When a mutation and a design write hit the same index in the same cycle, the mutation value is stored.
- R8: Mode 0 (random) writes the LFSR state repeated across the entry and cut to DATA_W bits.
- R9: Mode 1 (pattern) writes `pattern_i`.
- R10: Mode 2 (steer) writes the random value with bit DATA_W-1 (valid) set, and with bits [BANK_LSB +: BANK_W] replaced by `target_i`.
- R11: Mode 3 (false target) writes the random value with bit DATA_W-1 (valid) set.
- R12: With `mut_en_i` low, no pulse is ever raised and the table holds exactly what the design wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | IDX_W | Read index |
| rd_data_o | output | DATA_W | Registered read data |
| wr_en_i | input | 1 | Design write enable |
| wr_addr_i | input | IDX_W | Design write index |
| wr_data_i | input | DATA_W | Design write data |
| mut_en_i | input | 1 | Mutation enable |
| mut_mode_i | input | 2 | Mode: 0 random, 1 pattern, 2 steer, 3 false target |
| seed_i | input | 16 | LFSR seed, taken at reset release |
| mut_period_i | input | PERIOD_W | Cycles between mutations |
| pattern_i | input | DATA_W | Pattern value for mode 1 |
| target_i | input | BANK_W | Bank field value for mode 2 |
| mut_pulse_o | output | 1 | High in each cycle in which a mutation is applied |
| mut_idx_o | output | IDX_W | Index being mutated |

## Verification
The bench builds the wrapper with DEPTH=12 and DATA_W=20. With 12 entries and 4-bit addresses, the modulo reduction is not a simple bit slice, and the bench can drive read and write addresses beyond the table. With a 20-bit entry, the repeated LFSR word is cut off partway through its second copy. BANK_LSB=6 and BANK_W=3 put the steering field in the middle of the entry, clear of the valid bit. PERIOD_W=4 lets the bench sweep every period value, including 0 and 1.

// File: rtl/fuzz_tbl_pkg.sv
package fuzz_tbl_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_FALLBACK = 16'hACE1;

  typedef enum logic [1:0] {
    MUT_RANDOM    = 2'd0,
    MUT_PATTERN   = 2'd1,
    MUT_STEER     = 2'd2,
    MUT_FALSE_TGT = 2'd3
  } mut_mode_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/fuzz_lfsr.sv
module fuzz_lfsr
  import fuzz_tbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] state_o,
  output logic              ready_o
);
  logic [LFSR_W-1:0] state_q;
  logic              ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      // seed captured on first edge after reset release
      state_q <= (seed_i == '0) ? LFSR_FALLBACK : seed_i;
      ready_q <= 1'b1;
    end else if (adv_i) begin
      state_q <= lfsr_step(state_q);
    end
  end

  assign state_o = state_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/fuzz_sched.sv
module fuzz_sched #(
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                ready_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                fire_o
);
  logic [PERIOD_W-1:0] cnt_q;

  assign fire_o = en_i && ready_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || !ready_i) begin
      cnt_q <= '0;
    end else if (fire_o) begin
      cnt_q <= (period_i == '0) ? '0 : period_i - 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fuzz_mutator.sv
module fuzz_mutator
  import fuzz_tbl_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BANK_LSB = 4,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned IDX_W    = 4
) (
  input  logic [LFSR_W-1:0] state_i,
  input  mut_mode_e         mode_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [BANK_W-1:0] target_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned REP = (DATA_W + LFSR_W - 1) / LFSR_W;
  localparam int unsigned VLD = DATA_W - 1;

  logic [DATA_W-1:0] rnd;

  assign idx_o = IDX_W'(state_i % LFSR_W'(DEPTH));
  assign rnd   = DATA_W'({REP{state_i}});

  always_comb begin
    data_o = rnd;
    unique case (mode_i)
      MUT_PATTERN: data_o = pattern_i;
      MUT_STEER: begin
        data_o[VLD]                 = 1'b1;
        data_o[BANK_LSB +: BANK_W]  = target_i;
      end
      MUT_FALSE_TGT: data_o[VLD] = 1'b1;
      default: data_o = rnd;
    endcase
  end
endmodule

// File: rtl/fuzz_shadow_mem.sv
module fuzz_shadow_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mut_we_i,
  input  logic [IDX_W-1:0]  mut_idx_i,
  input  logic [DATA_W-1:0] mut_data_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] nxt   [DEPTH];
  logic [DATA_W-1:0] rd_q;

  // mutation write applied after design write: mutation wins
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = mem_q[i];
      if (wr_en_i && wr_addr_i == IDX_W'(i)) nxt[i] = wr_data_i;
      if (mut_we_i && mut_idx_i == IDX_W'(i)) nxt[i] = mut_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= nxt[i];
    end
  end

  // write-first read: returns the post-write entry value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= (int'(rd_addr_i) < DEPTH) ? nxt[rd_addr_i] : '0;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/fuzz_table_wrap.sv
module fuzz_table_wrap
  import fuzz_tbl_pkg::*;
#(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 8,
  parameter int unsigned BANK_LSB = 4,
  parameter int unsigned BANK_W   = 2,
  localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [IDX_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                mut_en_i,
  input  logic [1:0]          mut_mode_i,
  input  logic [15:0]         seed_i,
  input  logic [PERIOD_W-1:0] mut_period_i,
  input  logic [DATA_W-1:0]   pattern_i,
  input  logic [BANK_W-1:0]   target_i,
  output logic                mut_pulse_o,
  output logic [IDX_W-1:0]    mut_idx_o
);
  logic [LFSR_W-1:0] lfsr_state;
  logic              lfsr_ready;
  logic              fire;
  logic [IDX_W-1:0]  m_idx;
  logic [DATA_W-1:0] m_data;

  fuzz_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .seed_i  (seed_i),
    .adv_i   (fire),
    .state_o (lfsr_state),
    .ready_o (lfsr_ready)
  );

  fuzz_sched #(.PERIOD_W(PERIOD_W)) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mut_en_i),
    .ready_i  (lfsr_ready),
    .period_i (mut_period_i),
    .fire_o   (fire)
  );

  fuzz_mutator #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_mut (
    .state_i   (lfsr_state),
    .mode_i    (mut_mode_e'(mut_mode_i)),
    .pattern_i (pattern_i),
    .target_i  (target_i),
    .idx_o     (m_idx),
    .data_o    (m_data)
  );

  fuzz_shadow_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mut_we_i   (fire),
    .mut_idx_i  (m_idx),
    .mut_data_i (m_data),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  assign mut_pulse_o = fire;
  assign mut_idx_o   = m_idx;
endmodule

// File: rtl/fuzz_table_wrap_chk.sv
module fuzz_table_wrap_chk #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 8,
  parameter int unsigned BANK_LSB = 4,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned IDX_W    = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_en_i,
  input logic [IDX_W-1:0]    rd_addr_i,
  input logic [DATA_W-1:0]   rd_data_o,
  input logic                mut_en_i,
  input logic [1:0]          mut_mode_i,
  input logic [PERIOD_W-1:0] mut_period_i,
  input logic [DATA_W-1:0]   pattern_i,
  input logic [BANK_W-1:0]   target_i,
  input logic                mut_pulse_o,
  input logic [IDX_W-1:0]    mut_idx_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_FIRST_EDGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !mut_pulse_o); // R3
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mut_pulse_o |-> mut_en_i); // R12
  AST_PERIOD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mut_pulse_o && mut_period_i > 1) |=> !mut_pulse_o); // R5
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mut_pulse_o |-> (int'(mut_idx_o) < DEPTH)); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R1
  AST_PATTERN_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mut_pulse_o && mut_mode_i == 2'd1 && rd_en_i && rd_addr_i == mut_idx_o)
    |=> rd_data_o == $past(pattern_i)); // R9
  AST_STEER_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mut_pulse_o && mut_mode_i == 2'd2 && rd_en_i && rd_addr_i == mut_idx_o)
    |=> (rd_data_o[DATA_W-1] && rd_data_o[BANK_LSB +: BANK_W] == $past(target_i))); // R10
  AST_FALSE_TGT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mut_pulse_o && mut_mode_i == 2'd3 && rd_en_i && rd_addr_i == mut_idx_o)
    |=> rd_data_o[DATA_W-1]); // R11
endmodule

bind fuzz_table_wrap fuzz_table_wrap_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W),
  .BANK_LSB(BANK_LSB), .BANK_W(BANK_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .mut_en_i     (mut_en_i),
  .mut_mode_i   (mut_mode_i),
  .mut_period_i (mut_period_i),
  .pattern_i    (pattern_i),
  .target_i     (target_i),
  .mut_pulse_o  (mut_pulse_o),
  .mut_idx_o    (mut_idx_o)
);

// File: tb/tb_fuzz_table_wrap.sv
`timescale 1ns/1ps
module tb_fuzz_table_wrap;
  localparam int DEPTH    = 12;
  localparam int DATA_W   = 20;
  localparam int PERIOD_W = 4;
  localparam int BANK_LSB = 6;
  localparam int BANK_W   = 3;
  localparam int IDX_W    = 4;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                rd_en_i = 1'b0;
  logic [IDX_W-1:0]    rd_addr_i = '0;
  logic [DATA_W-1:0]   rd_data_o;
  logic                wr_en_i = 1'b0;
  logic [IDX_W-1:0]    wr_addr_i = '0;
  logic [DATA_W-1:0]   wr_data_i = '0;
  logic                mut_en_i = 1'b0;
  logic [1:0]          mut_mode_i = '0;
  logic [15:0]         seed_i = '0;
  logic [PERIOD_W-1:0] mut_period_i = '0;
  logic [DATA_W-1:0]   pattern_i = '0;
  logic [BANK_W-1:0]   target_i = '0;
  logic                mut_pulse_o;
  logic [IDX_W-1:0]    mut_idx_o;

  always #10 clk_i = ~clk_i;

  fuzz_table_wrap #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)
  ) dut (.*);

  // behavioural reference
  logic [DATA_W-1:0] m_mem [DEPTH];
  logic [DATA_W-1:0] m_rdata;
  logic [15:0]       m_s;
  int                m_cnt;
  bit                m_seeded;
  int                n_vec = 0;
  int                n_bad = 0;

  function automatic logic [15:0] ref_step(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic bit ref_fire();
    return m_seeded && mut_en_i && (m_cnt == 0);
  endfunction

  function automatic int ref_idx();
    return int'(m_s) % DEPTH;
  endfunction

  function automatic logic [DATA_W-1:0] ref_val();
    logic [31:0] r;
    logic [DATA_W-1:0] v;
    r = {m_s, m_s};
    v = r[DATA_W-1:0];
    case (mut_mode_i)
      2'd1: v = pattern_i;
      2'd2: begin v[DATA_W-1] = 1'b1; v[BANK_LSB +: BANK_W] = target_i; end
      2'd3: v[DATA_W-1] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

  task automatic ref_update();
    bit f;
    f = ref_fire();
    if (wr_en_i && int'(wr_addr_i) < DEPTH) m_mem[wr_addr_i] = wr_data_i;
    if (f) m_mem[ref_idx()] = ref_val();
    if (rd_en_i) m_rdata = (int'(rd_addr_i) < DEPTH) ? m_mem[rd_addr_i] : '0;
    if (!m_seeded) begin
      m_s = (seed_i == 16'h0) ? 16'hACE1 : seed_i;
      m_seeded = 1'b1;
      m_cnt = 0;
    end else begin
      if (f) m_s = ref_step(m_s);
      if (!mut_en_i) m_cnt = 0;
      else if (f) m_cnt = (mut_period_i == 0) ? 0 : int'(mut_period_i) - 1;
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // caller drives inputs just after a falling edge, then calls tick
  task automatic tick(string req);
    #2;
    chk(req, 32'(mut_pulse_o), 32'(ref_fire()));
    if (ref_fire()) chk(req, 32'(mut_idx_o), 32'(ref_idx()));
    @(posedge clk_i);
    ref_update();
    @(negedge clk_i);
    chk(req, 32'(rd_data_o), 32'(m_rdata));
  endtask

  task automatic do_reset(logic [15:0] seed);
    rst_ni = 1'b0;
    rd_en_i = 0; wr_en_i = 0; mut_en_i = 0; seed_i = seed;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_rdata = '0; m_s = '0; m_cnt = 0; m_seeded = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1", 32'(rd_data_o), 32'h0);
    chk("R1", 32'(mut_pulse_o), 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic rand_bus(bit aim);
    rd_en_i   = ($urandom % 4) != 0;
    wr_en_i   = ($urandom % 2) != 0;
    wr_addr_i = IDX_W'($urandom % DEPTH);
    wr_data_i = DATA_W'($urandom);
    rd_addr_i = (aim && ref_fire()) ? IDX_W'(ref_idx()) : IDX_W'($urandom % DEPTH);
    if (!aim && ($urandom % 4) == 0) rd_addr_i = wr_addr_i;
  endtask

  task automatic read_all(string req);
    wr_en_i = 0; mut_en_i = 0; rd_en_i = 1;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr_i = IDX_W'(i);
      tick(req);
    end
  endtask

  initial begin
    do_reset(16'h1234);
    // plain table, write-first collisions
    for (int i = 0; i < 40; i++) begin rand_bus(0); tick("R2"); end
    wr_en_i = 1; wr_addr_i = 4'd5; wr_data_i = 20'hABCDE; rd_en_i = 1; rd_addr_i = 4'd5;
    tick("R2");
    wr_addr_i = 4'd14; wr_data_i = 20'h11111; rd_addr_i = 4'd13; tick("R1");
    rd_en_i = 0; wr_addr_i = 4'd5; wr_data_i = 20'h22222; tick("R1");
    read_all("R12");

    // random mode, sequence of indices
    mut_en_i = 1; mut_mode_i = 2'd0; mut_period_i = 4'd1;
    for (int i = 0; i < 30; i++) begin rand_bus(1); tick("R4"); end
    mut_period_i = 4'd3;
    for (int i = 0; i < 30; i++) begin rand_bus(1); tick("R8"); end
    read_all("R8");
    mut_en_i = 1;
    for (int p = 0; p < 16; p++) begin
      mut_period_i = PERIOD_W'(p);
      for (int i = 0; i < 20; i++) begin rand_bus(1); tick("R5"); end
    end

    // pattern mode
    mut_mode_i = 2'd1; mut_period_i = 4'd2;
    for (int i = 0; i < 30; i++) begin pattern_i = DATA_W'($urandom); rand_bus(1); tick("R9"); end
    mut_period_i = 4'd1;
    for (int i = 0; i < 20; i++) begin pattern_i = DATA_W'($urandom); rand_bus(1); tick("R6"); end
    // mutation against design write, same index
    for (int i = 0; i < 20; i++) begin
      pattern_i = DATA_W'($urandom);
      wr_en_i = 1; wr_data_i = DATA_W'($urandom);
      wr_addr_i = IDX_W'(ref_idx()); rd_en_i = 1; rd_addr_i = wr_addr_i;
      tick("R7");
    end

    // steering and false-target modes
    mut_mode_i = 2'd2; mut_period_i = 4'd2;
    for (int i = 0; i < 40; i++) begin target_i = BANK_W'($urandom); rand_bus(1); tick("R10"); end
    read_all("R10");
    mut_en_i = 1; mut_mode_i = 2'd3; mut_period_i = 4'd0;
    for (int i = 0; i < 40; i++) begin rand_bus(1); tick("R11"); end

    // disabled again: plain table
    mut_en_i = 0; mut_period_i = 4'd1;
    for (int i = 0; i < 40; i++) begin rand_bus(0); tick("R12"); end
    read_all("R12");

    // zero seed falls back, enable present from release
    do_reset(16'h0000);
    mut_en_i = 1; mut_mode_i = 2'd0; mut_period_i = 4'd1;
    for (int i = 0; i < 25; i++) begin rand_bus(1); tick("R3"); end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule